// File: doc/BRIEF.md
# Instruction-Cycle Timer with Prescaler and Watchdog

This block derives an instruction-cycle strobe from the oscillator clock, dividing by two or by four. That strobe drives an 8-bit up-counting timer. Software may place a shared 8-bit prescaler between the strobe and the timer. The prescaler divides by a power of two that a 3-bit select field picks. Whenever the timer is written, the prescaler is cleared. The timer raises a one-clock interrupt each time it rolls over from its top value to zero.

A separate 8-bit watchdog counts pulses on a slow tick input while it is enabled. The enable may be changed at any time. If software does not clear the count with a strobe in time, the watchdog expires. A mode bit routes the expiry either to a one-clock reset request or to a one-clock interrupt. In both modes expiry sets a sticky timeout flag, which stays set until software clears it.

Top module: `cyc_timer_wdt`

## Requirements
- R1: The instruction-cycle strobe fires once every 2 clocks when `cfg_div4`=0 and once every 4 clocks when `cfg_div4`=1. A 2-bit phase counter starts at 0 after reset. The strobe fires on odd phases in the first setting and on phase 3 in the second.
- R2: With `cfg_pre_en`=0, the timer advances by one on every instruction-cycle strobe and wraps modulo 256.
- R3: With `cfg_pre_en`=1, the timer advances once every 2^(`cfg_pre_sel`+1) instruction cycles (1:2 through 1:256). The free-running 8-bit prescale count increments on each strobe. The timer steps on a strobe at which the low `cfg_pre_sel`+1 bits of that count are all ones.
- R4: A `tmr_wr` pulse loads `tmr_wdata` into the timer on the next clock, taking priority over an increment in the same cycle. The same pulse resets the prescale count to zero.
- R5: `tmr_ovf_irq` is high for exactly one clock, the clock in which the timer has just stepped from 0xFF to 0x00 by incrementing. A write never raises it.
- R6: While `wdt_en`=1 the watchdog count advances on each `wdt_tick`. `wdt_clr`=1 or `wdt_en`=0 forces the count to zero, so no expiry can occur.
- R7: The watchdog expires when a tick arrives with the count at 255 while it is enabled and not being cleared. The count then restarts at 0, and `wdt_timeout` is set on the next clock.
- R8: On expiry, `wdt_mode`=0 gives a one-clock `wdt_rst_req` and `wdt_mode`=1 gives a one-clock `wdt_irq`. Both are never high together.
- R9: `wdt_timeout` stays set until `wdt_flag_clr` is high at a clock edge. An expiry at the same edge wins over the clear.
- R10: After reset, the timer value, all three pulse outputs and the timeout flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div4 | input | 1 | Instruction cycle = oscillator /4 when 1, /2 when 0 |
| cfg_pre_en | input | 1 | Route the timer through the prescaler |
| cfg_pre_sel | input | 3 | Prescaler ratio select, ratio 2^(sel+1) |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write value |
| wdt_en | input | 1 | Watchdog enable |
| wdt_mode | input | 1 | Expiry route: 0 reset request, 1 interrupt |
| wdt_clr | input | 1 | Watchdog count clear strobe |
| wdt_tick | input | 1 | Slow watchdog tick, one clock wide |
| wdt_flag_clr | input | 1 | Clear the sticky timeout flag |
| tmr_val | output | 8 | Current timer value |
| tmr_ovf_irq | output | 1 | Timer rollover interrupt pulse |
| wdt_rst_req | output | 1 | Watchdog reset request pulse |
| wdt_irq | output | 1 | Watchdog interrupt pulse |
| wdt_timeout | output | 1 | Sticky watchdog timeout flag |

## Verification
The hardest case to reach is a timer rollover at the slowest prescale ratio. With the /2 instruction clock, one timer step at 1:256 takes 512 clocks, and a rollover from zero would take far longer than the run allows. The stimulus therefore writes 0xFE into the timer, which also zeroes the prescaler, and then runs long enough for two steps. A second hard case is a flag clear that coincides with a watchdog expiry. The bench holds `wdt_flag_clr` high across an expiry, so that the set-over-clear precedence is exercised at exactly that edge. The reference model checks the result on every clock.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  localparam int TMR_W_DEF = 8;
  localparam int PRE_W_DEF = 8;
  localparam int SEL_W_DEF = 3;
  localparam int WDT_W_DEF = 8;

  typedef enum logic {
    WDT_ROUTE_RESET = 1'b0,
    WDT_ROUTE_IRQ   = 1'b1
  } wdt_route_e;
endpackage

// File: rtl/icyc_gen.sv
module icyc_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic div4,
  output logic cyc_en
);
  logic [1:0] phase_q;

  // strobe position within the 4-phase ring
  function automatic logic strobe_at(input logic [1:0] ph, input logic by4);
    return by4 ? (ph == 2'd3) : ph[0];
  endfunction

  assign cyc_en = strobe_at(phase_q, div4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 2'd0;
    else        phase_q <= phase_q + 2'd1;
  end

  // R1: two strobes are never adjacent in either setting
  assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en |=> !cyc_en);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             clr,
  input  logic             pre_en,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;
  logic             pre_hit;

  // low sel+1 bits set: ratio 2^(sel+1)
  function automatic logic [PRE_W-1:0] ratio_mask(input logic [SEL_W-1:0] s);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i <= int'(s));
    return m;
  endfunction

  assign mask    = ratio_mask(sel);
  assign pre_hit = cyc_en && ((cnt_q & mask) == mask);
  assign step    = pre_en ? pre_hit : cyc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (cyc_en) cnt_q <= cnt_q + 1'b1;
  end

  // R4: a timer write leaves the prescale count at zero
  assert_clear_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R3: a prescaled step only happens on an instruction cycle
  assert_step_on_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cyc_en);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wr,
  input  logic [TMR_W-1:0] wdata,
  output logic [TMR_W-1:0] val,
  output logic             ovf_irq
);
  logic [TMR_W-1:0] val_q;
  logic             wrap_evt;

  assign wrap_evt = step && !wr && (&val_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      ovf_irq <= 1'b0;
    end else begin
      ovf_irq <= wrap_evt;
      if (wr)        val_q <= wdata;
      else if (step) val_q <= val_q + 1'b1;
    end
  end

  assign val = val_q;

  // R4: write data lands on the next clock
  assert_write_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (val_q == $past(wdata)));
  // R5: interrupt only with the counter at zero
  assert_irq_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (val_q == '0));
  // R5: one clock wide
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import cyc_timer_pkg::*;
#(
  parameter int WDT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  wdt_route_e route,
  input  logic       clr,
  input  logic       tick,
  input  logic       flag_clr,
  output logic       rst_req,
  output logic       irq,
  output logic       timeout
);
  logic [WDT_W-1:0] cnt_q;
  logic             expire;
  logic             hold_zero;

  assign hold_zero = clr || !en;
  assign expire    = !hold_zero && tick && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
      timeout <= 1'b0;
    end else begin
      if (hold_zero) cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
      rst_req <= expire && (route == WDT_ROUTE_RESET);
      irq     <= expire && (route == WDT_ROUTE_IRQ);
      if (expire)        timeout <= 1'b1;
      else if (flag_clr) timeout <= 1'b0;
    end
  end

  // R6: disabled or cleared watchdog sits at zero
  assert_held_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |=> (cnt_q == '0));
  // R7: expiry sets the flag
  assert_expiry_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> timeout);
  // R8: routes are exclusive
  assert_one_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq));
  // R9: flag falls only on a clear request
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout) |-> $past(flag_clr));
endmodule

// File: rtl/cyc_timer_wdt.sv
module cyc_timer_wdt
  import cyc_timer_pkg::*;
#(
  parameter int TMR_W = TMR_W_DEF,
  parameter int PRE_W = PRE_W_DEF,
  parameter int SEL_W = SEL_W_DEF,
  parameter int WDT_W = WDT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_div4,
  input  logic             cfg_pre_en,
  input  logic [SEL_W-1:0] cfg_pre_sel,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             wdt_en,
  input  logic             wdt_mode,
  input  logic             wdt_clr,
  input  logic             wdt_tick,
  input  logic             wdt_flag_clr,
  output logic [TMR_W-1:0] tmr_val,
  output logic             tmr_ovf_irq,
  output logic             wdt_rst_req,
  output logic             wdt_irq,
  output logic             wdt_timeout
);
  logic       cyc_en;
  logic       tmr_step;
  wdt_route_e route;

  assign route = wdt_route_e'(wdt_mode);

  icyc_gen u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .div4   (cfg_div4),
    .cyc_en (cyc_en)
  );

  tmr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .cyc_en (cyc_en),
    .clr    (tmr_wr),
    .pre_en (cfg_pre_en),
    .sel    (cfg_pre_sel),
    .step   (tmr_step)
  );

  tmr_counter #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (tmr_step),
    .wr      (tmr_wr),
    .wdata   (tmr_wdata),
    .val     (tmr_val),
    .ovf_irq (tmr_ovf_irq)
  );

  wdt_core #(.WDT_W(WDT_W)) u_wdt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (wdt_en),
    .route    (route),
    .clr      (wdt_clr),
    .tick     (wdt_tick),
    .flag_clr (wdt_flag_clr),
    .rst_req  (wdt_rst_req),
    .irq      (wdt_irq),
    .timeout  (wdt_timeout)
  );

  // R2: with the prescaler bypassed the timer moves by at most one per clock
  assert_bypass_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pre_en && !tmr_wr && !$past(tmr_wr)) |=>
      ((tmr_val == $past(tmr_val)) || (tmr_val == $past(tmr_val) + 1'b1)));
endmodule

// File: tb/cyc_timer_wdt_tb.sv
module cyc_timer_wdt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_div4 = 1'b0, cfg_pre_en = 1'b0;
  logic [2:0] cfg_pre_sel = 3'd0;
  logic       tmr_wr = 1'b0;
  logic [7:0] tmr_wdata = 8'd0;
  logic       wdt_en = 1'b0, wdt_mode = 1'b0, wdt_clr = 1'b0, wdt_tick = 1'b0, wdt_flag_clr = 1'b0;
  logic [7:0] tmr_val;
  logic       tmr_ovf_irq, wdt_rst_req, wdt_irq, wdt_timeout;

  int total = 0, bad = 0, cycles = 0, tick_gap = 0;

  // behavioural reference state
  int m_ph, m_pre, m_tmr, m_wc;
  bit m_ovf, m_rq, m_irq, m_flag;

  always #10 clk = ~clk;  // 50 MHz

  cyc_timer_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div4(cfg_div4), .cfg_pre_en(cfg_pre_en),
    .cfg_pre_sel(cfg_pre_sel), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .wdt_en(wdt_en), .wdt_mode(wdt_mode), .wdt_clr(wdt_clr), .wdt_tick(wdt_tick),
    .wdt_flag_clr(wdt_flag_clr), .tmr_val(tmr_val), .tmr_ovf_irq(tmr_ovf_irq),
    .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq), .wdt_timeout(wdt_timeout)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act, exp);
    end
  endtask

  // reference model update
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ph = 0; m_pre = 0; m_tmr = 0; m_wc = 0;
      m_ovf = 0; m_rq = 0; m_irq = 0; m_flag = 0;
    end else begin
      bit cyc, tick, ex;
      int ratio;
      cyc   = cfg_div4 ? (m_ph == 3) : (m_ph % 2 == 1);          // R1
      ratio = 2 ** (int'(cfg_pre_sel) + 1);                      // R3
      tick  = cfg_pre_en ? (cyc && ((m_pre % ratio) == ratio - 1)) : cyc;  // R2
      m_ph  = (m_ph + 1) % 4;
      m_ovf = !tmr_wr && tick && (m_tmr == 255);                 // R5
      if (tmr_wr) begin m_tmr = int'(tmr_wdata); m_pre = 0; end  // R4
      else begin
        if (tick) m_tmr = (m_tmr + 1) % 256;
        if (cyc)  m_pre = (m_pre + 1) % 256;
      end
      ex = wdt_en && !wdt_clr && wdt_tick && (m_wc == 255);      // R7
      if (!wdt_en || wdt_clr) m_wc = 0;                          // R6
      else if (wdt_tick) m_wc = (m_wc + 1) % 256;
      m_rq  = ex && !wdt_mode;                                   // R8
      m_irq = ex && wdt_mode;
      if (ex) m_flag = 1; else if (wdt_flag_clr) m_flag = 0;     // R9
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      check("R10 tmr_val", int'(tmr_val), 0);
      check("R10 pulses", int'({tmr_ovf_irq, wdt_rst_req, wdt_irq}), 0);
      check("R10 timeout", int'(wdt_timeout), 0);
    end else begin
      check("R2/R3/R4 tmr_val", int'(tmr_val), m_tmr);
      check("R5 tmr_ovf_irq", int'(tmr_ovf_irq), int'(m_ovf));
      check("R8 wdt_rst_req", int'(wdt_rst_req), int'(m_rq));
      check("R8 wdt_irq", int'(wdt_irq), int'(m_irq));
      check("R7/R9 wdt_timeout", int'(wdt_timeout), int'(m_flag));
    end
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tmr_wr  = 1'b0;
      wdt_clr = 1'b0;
      wdt_tick = (tick_gap != 0) && (i % tick_gap == 0);
    end
  endtask

  task automatic write_tmr(input logic [7:0] v);
    @(negedge clk);
    tmr_wr = 1'b1; tmr_wdata = v; wdt_tick = 1'b0;
  endtask

  initial begin
    run(5);
    rst_n = 1'b1;
    // R1 R2: bypass at /2, then /4, with rollovers (R5)
    run(600);
    cfg_div4 = 1'b1;
    run(1100);
    // R4: write near the top, then roll over
    write_tmr(8'hF0);
    run(80);
    cfg_div4 = 1'b0;
    // R3: each ratio, with a mid-count write clearing the prescaler
    for (int s = 0; s < 7; s++) begin
      cfg_pre_en = 1'b1; cfg_pre_sel = 3'(s);
      write_tmr(8'hFD);
      run(37);
      write_tmr(8'hFD);   // R4: clears partial prescale
      run(600);
    end
    // R3: slowest ratio, rollover reached from 0xFE
    cfg_pre_sel = 3'd7;
    write_tmr(8'hFE);
    run(1100);
    cfg_pre_en = 1'b0;
    // R6 R7 R8: watchdog, reset route, with a clear mid-way
    wdt_en = 1'b1; wdt_mode = 1'b0; tick_gap = 2;
    run(300);
    @(negedge clk); wdt_clr = 1'b1;
    run(1200);
    // R9: flag clear, then interrupt route
    wdt_flag_clr = 1'b1;
    run(4);
    wdt_flag_clr = 1'b0;
    wdt_mode = 1'b1;
    run(600);
    // R9: clear held across an expiry, set wins
    wdt_flag_clr = 1'b1;
    run(600);
    wdt_flag_clr = 1'b0;
    // R6: disable mid-count, no expiry
    run(200);
    wdt_en = 1'b0;
    run(700);
    wdt_en = 1'b1; tick_gap = 1;
    run(600);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule